// File: doc/BRIEF.md
# Frame Buffer Overwrite Write Port

This block is the write side of a pair of pixel frame buffers held as 16-bit words. A host issues byte or halfword writes with an address, a data word, a size flag and a bank select. Each buffer is reachable through two aliased windows over the same storage. An address bit above the buffer offset picks the window. In the plain window, halfword writes replace the stored word. In the overwrite window, a zero byte is treated as transparent, so the stored pixel byte survives. Byte writes carrying zero never store anything, in either window.

A byte write targets one lane of a halfword, and the lane order is big-endian: an even byte address hits bits [15:8] and an odd one hits bits [7:0]. A halfword write to the overwrite window needs the old word. The controller therefore runs a read-modify-write against the synchronous bank RAM and stalls the requester for one cycle. A separate read port returns stored halfwords one cycle after the request, so stored contents can be observed.

The controller has two states. In `S_IDLE`, `req_ready` is high and any request is accepted. A plain-window halfword write or a byte write is committed at the accepting edge. An overwrite-window halfword write instead issues a read of the old word and takes the transition IDLE→MERGE. In `S_MERGE`, `req_ready` is low, the stored word is merged lane by lane with the captured data and written back, and the transition MERGE→IDLE follows unconditionally.

Top module: `fbw_port`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid` is 0.
- R2: A byte write with nonzero `req_data[7:0]` stores that byte at halfword index `req_addr[ADDR_W-1:1]`. It goes in bits [15:8] when `req_addr[0]`=0 and in bits [7:0] when `req_addr[0]`=1. The other lane is unchanged.
- R3: A byte write with `req_data[7:0]`=0 is accepted (`req_ready` stays 1 on the next cycle) but changes no stored data, in both windows.
- R4: For byte writes, the window bit `req_addr[ADDR_W]` does not change where or whether the byte is stored.
- R5: A halfword write with `req_addr[ADDR_W]`=0 stores all 16 bits of `req_data`, zeros included.
- R6: A halfword write with `req_addr[ADDR_W]`=1 updates each byte lane independently. A nonzero new lane replaces the stored lane, and a zero new lane keeps the stored lane.
- R7: After accepting an overwrite-window halfword write, `req_ready` is 0 for exactly one cycle and then returns to 1. No other write lowers `req_ready`.
- R8: `req_bank` selects which of the two buffers a write changes. The other buffer keeps its contents.
- R9: A read request (`rd_en`=1) returns the stored halfword of bank `rd_bank` at index `rd_idx` on `rd_data`, with `rd_valid`=1, one cycle later.
- R10: For halfword writes, `req_addr[0]` is ignored, and the word lands at index `req_addr[ADDR_W-1:1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Port can accept a write this cycle |
| req_addr | input | ADDR_W+1 | Byte address; top bit selects the overwrite window |
| req_data | input | 16 | Write data; byte writes use bits [7:0] |
| req_is_byte | input | 1 | 1 = byte write, 0 = halfword write |
| req_bank | input | BANK_W | Target buffer |
| rd_en | input | 1 | Read request |
| rd_bank | input | BANK_W | Buffer to read |
| rd_idx | input | ADDR_W-1 | Halfword index to read |
| rd_data | output | 16 | Read result |
| rd_valid | output | 1 | `rd_data` holds a result |

## Verification
Plain-window and byte writes are committed at the accepting edge. Overwrite-window halfword writes are committed one edge later, at the end of the `S_MERGE` cycle. A read returns its data after the edge following its request. The bench drives inputs on the falling edge and samples on the next falling edge. It checks `req_ready` one cycle after each acceptance, and once more for merges. It starts any readback only after `req_ready` is high again, so every write has landed before the read is issued. The expected contents come from a bench model of both buffers that applies the lane, zero-suppression and merge rules.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_MERGE = 1'b1
    } fbw_state_e;

    typedef struct packed {
        logic [1:0]  be;
        logic [15:0] wdata;
    } lane_wr_t;

endpackage

// File: rtl/fbw_lane_logic.sv
module fbw_lane_logic (
    input  logic             is_byte,
    input  logic             addr_lsb,
    input  logic             ow_area,
    input  logic [15:0]      req_data,
    input  logic [15:0]      old_word,
    input  logic [15:0]      pend_data,
    output fbw_pkg::lane_wr_t direct,
    output logic             need_merge,
    output logic [15:0]      merged
);
    logic [7:0] byte_val;

    assign byte_val   = req_data[7:0];
    assign need_merge = !is_byte && ow_area;

    // Direct path: byte steering with zero suppression, plain halfword store
    always_comb begin
        direct.wdata = req_data;
        direct.be    = 2'b00;
        if (is_byte) begin
            direct.wdata = {byte_val, byte_val};
            if (byte_val != 8'h00)
                direct.be = addr_lsb ? 2'b01 : 2'b10;
        end else if (!ow_area) begin
            direct.be = 2'b11;
        end
    end

    // Merge path: each lane keeps the stored byte when the new byte is zero
    for (genvar l = 0; l < 2; l++) begin : g_lane
        assign merged[8*l +: 8] = (pend_data[8*l +: 8] != 8'h00)
                                  ? pend_data[8*l +: 8]
                                  : old_word[8*l +: 8];
    end

endmodule

// File: rtl/fbw_ctrl.sv
module fbw_ctrl
    import fbw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       need_merge,
    output logic       ready,
    output logic       accept,
    output logic       start_merge,
    output logic       merge_we,
    output fbw_state_e state_o
);
    fbw_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid && need_merge) state_nx = S_MERGE;
            S_MERGE: state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        ready       = (state == S_IDLE);
        accept      = req_valid && ready;
        start_merge = accept && need_merge;
        merge_we    = (state == S_MERGE);
        state_o     = state;
    end

    assert_merge_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_merge |=> !ready);

    assert_merge_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        merge_we |=> ready);

    assert_plain_write_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !need_merge) |=> ready);

endmodule

// File: rtl/fbw_bank_ram.sv
module fbw_bank_ram #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             we,
    input  logic [1:0]       be,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [15:0]      w_data,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    output logic [15:0]      a_q,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    output logic [15:0]      b_q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [15:0] mem [DEPTH];

    for (genvar l = 0; l < 2; l++) begin : g_wlane
        always_ff @(posedge clk) begin
            if (we && be[l]) mem[w_idx][8*l +: 8] <= w_data[8*l +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (a_en) a_q <= mem[a_idx];
        if (b_en) b_q <= mem[b_idx];
    end

endmodule

// File: rtl/fbw_port.sv
module fbw_port
    import fbw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [15:0]       req_data,
    input  logic              req_is_byte,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              rd_en,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [ADDR_W-2:0] rd_idx,
    output logic [15:0]       rd_data,
    output logic              rd_valid
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int NBANK = 1 << BANK_W;

    logic [IDX_W-1:0]  req_idx;
    logic              ow_area;
    lane_wr_t          direct;
    logic              need_merge;
    logic [15:0]       merged;
    logic              accept, start_merge, merge_we;
    fbw_state_e        state;

    logic [BANK_W-1:0] pend_bank;
    logic [IDX_W-1:0]  pend_idx;
    logic [15:0]       pend_data;
    logic [BANK_W-1:0] rd_bank_q;

    logic [NBANK-1:0]  bank_we;
    logic [1:0]        wr_be;
    logic [IDX_W-1:0]  wr_idx;
    logic [15:0]       wr_data;
    logic [15:0]       a_q [NBANK];
    logic [15:0]       b_q [NBANK];

    assign req_idx = req_addr[ADDR_W-1:1];
    assign ow_area = req_addr[ADDR_W];

    fbw_lane_logic u_lane (
        .is_byte    (req_is_byte),
        .addr_lsb   (req_addr[0]),
        .ow_area    (ow_area),
        .req_data   (req_data),
        .old_word   (a_q[pend_bank]),
        .pend_data  (pend_data),
        .direct     (direct),
        .need_merge (need_merge),
        .merged     (merged)
    );

    fbw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .need_merge  (need_merge),
        .ready       (req_ready),
        .accept      (accept),
        .start_merge (start_merge),
        .merge_we    (merge_we),
        .state_o     (state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_bank <= '0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else if (start_merge) begin
            pend_bank <= req_bank;
            pend_idx  <= req_idx;
            pend_data <= req_data;
        end
    end

    always_comb begin
        wr_be   = merge_we ? 2'b11     : direct.be;
        wr_idx  = merge_we ? pend_idx  : req_idx;
        wr_data = merge_we ? merged    : direct.wdata;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_we[b] = (merge_we && pend_bank == BANK_W'(b)) ||
                            (accept && !need_merge && req_bank == BANK_W'(b) && (direct.be != 2'b00));

        fbw_bank_ram #(.IDX_W(IDX_W)) u_ram (
            .clk    (clk),
            .we     (bank_we[b]),
            .be     (wr_be),
            .w_idx  (wr_idx),
            .w_data (wr_data),
            .a_en   (start_merge && req_bank == BANK_W'(b)),
            .a_idx  (req_idx),
            .a_q    (a_q[b]),
            .b_en   (rd_en && rd_bank == BANK_W'(b)),
            .b_idx  (rd_idx),
            .b_q    (b_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_bank_q <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_bank_q <= rd_bank;
        end
    end

    assign rd_data = b_q[rd_bank_q];

    assert_zero_byte_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_is_byte && req_data[7:0] == 8'h00) |-> (bank_we == '0));

    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_is_byte) |-> ($countones(wr_be) <= 1));

    assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_merge_writes_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MERGE) |-> (bank_we != '0));

endmodule

// File: tb/test_fbw_port.sv
module test_fbw_port;
    localparam int ADDR_W = 12;
    localparam int NIDX   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W:0]   req_addr = '0;
    logic [15:0]       req_data = '0;
    logic              req_is_byte = 1'b0;
    logic [0:0]        req_bank = '0;
    logic              rd_en = 1'b0;
    logic [0:0]        rd_bank = '0;
    logic [ADDR_W-2:0] rd_idx = '0;
    logic [15:0]       rd_data;
    logic              rd_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model [2][NIDX];

    always #2 clk = ~clk;

    fbw_port #(.ADDR_W(ADDR_W), .BANK_W(1)) i_fbw_port (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .req_is_byte(req_is_byte), .req_bank(req_bank),
        .rd_en(rd_en), .rd_bank(rd_bank), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] f_byte(input logic [15:0] old, input bit lsb, input logic [7:0] b);
        if (b == 8'h00) return old;
        return lsb ? {old[15:8], b} : {b, old[7:0]};
    endfunction

    function automatic logic [15:0] f_merge(input logic [15:0] old, input logic [15:0] d);
        return {(d[15:8] != 0) ? d[15:8] : old[15:8], (d[7:0] != 0) ? d[7:0] : old[7:0]};
    endfunction

    task automatic do_write(input int bank, input int idx, input bit lsb, input bit ow,
                            input bit isb, input logic [15:0] d, input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = {ow, ADDR_W'(idx * 2 + int'(lsb))};
        req_data    = d;
        req_is_byte = isb;
        req_bank    = 1'(bank);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (isb || !ow) begin
            check(req_ready == 1'b1, {req, "/R7 ready after plain write"}, 16'(req_ready), 16'h1);
        end else begin
            check(req_ready == 1'b0, {req, "/R7 stall after merge accept"}, 16'(req_ready), 16'h0);
            @(negedge clk);
            check(req_ready == 1'b1, {req, "/R7 ready after merge"}, 16'(req_ready), 16'h1);
        end
        if (isb)     model[bank][idx] = f_byte(model[bank][idx], lsb, d[7:0]);
        else if (ow) model[bank][idx] = f_merge(model[bank][idx], d);
        else         model[bank][idx] = d;
    endtask

    task automatic do_read(input int bank, input int idx, input string req);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_bank = 1'(bank);
        rd_idx  = (ADDR_W-1)'(idx);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid == 1'b1, {req, "/R9 rd_valid"}, 16'(rd_valid), 16'h1);
        check(rd_data == model[bank][idx], req, rd_data, model[bank][idx]);
    endtask

    function automatic logic [7:0] rnd_byte();
        return ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
    endfunction

    initial begin : watchdog
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", 16'(req_ready), 16'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 16'(req_ready), 16'h1);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", 16'(rd_valid), 16'h0);

        for (int b = 0; b < 2; b++)
            for (int i = 0; i < NIDX; i++) begin
                do_write(b, i, 1'b0, 1'b0, 1'b0, 16'($urandom) | 16'h0101, "R5 init");
                do_read(b, i, "R5 init readback");
            end

        // Directed corner cases
        do_write(0, 3, 1'b0, 1'b0, 1'b1, 16'h00A5, "R2");
        do_read(0, 3, "R2 even byte to upper lane");
        do_write(0, 3, 1'b1, 1'b0, 1'b1, 16'h003C, "R2");
        do_read(0, 3, "R2 odd byte to lower lane");
        do_write(0, 4, 1'b0, 1'b0, 1'b1, 16'hFF00, "R3");
        do_read(0, 4, "R3 zero byte plain window ignored");
        do_write(0, 4, 1'b1, 1'b1, 1'b1, 16'h1200, "R3");
        do_read(0, 4, "R3 zero byte overwrite window ignored");
        do_write(1, 5, 1'b1, 1'b1, 1'b1, 16'h0077, "R4");
        do_read(1, 5, "R4 byte in overwrite window stored");
        do_write(0, 6, 1'b0, 1'b0, 1'b0, 16'h0000, "R5");
        do_read(0, 6, "R5 plain halfword zero stored");
        do_write(0, 7, 1'b0, 1'b1, 1'b0, 16'h00AB, "R6");
        do_read(0, 7, "R6 upper lane kept");
        do_write(0, 7, 1'b0, 1'b1, 1'b0, 16'hCD00, "R6");
        do_read(0, 7, "R6 lower lane kept");
        do_write(0, 8, 1'b0, 1'b1, 1'b0, 16'h0000, "R6");
        do_read(0, 8, "R6 both lanes kept");
        do_write(0, 8, 1'b0, 1'b1, 1'b0, 16'h1234, "R6");
        do_read(0, 8, "R6 both lanes replaced");
        do_write(1, 9, 1'b0, 1'b0, 1'b0, 16'hBEEF, "R8");
        do_read(0, 9, "R8 other bank untouched");
        do_read(1, 9, "R8 selected bank written");
        do_write(1, 10, 1'b1, 1'b0, 1'b0, 16'h5A5A, "R10");
        do_read(1, 10, "R10 halfword ignores address bit 0");
        @(negedge clk);
        check(rd_valid == 1'b0, "R9 rd_valid drops without request", 16'(rd_valid), 16'h0);

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            int b, i, kind;
            bit lsb;
            logic [15:0] d;
            b    = int'($urandom % 2);
            i    = int'($urandom % NIDX);
            kind = int'($urandom % 4);
            lsb  = 1'($urandom);
            d    = {rnd_byte(), rnd_byte()};
            do_write(b, i, lsb, kind[0], kind[1] == 1'b0, d, "random write");
            do_read(b, i, "R2/R3/R5/R6 random readback");
            if (n % 8 == 0) do_read(1 - b, i, "R8 random other bank");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule